// File: doc/BRIEF.md
# Power-Mode and Reset Supervisor

This block decides which power mode a mixed-signal device is in: normal, shutdown or sleep. Three kinds of event move it between modes. General-purpose pins can be assigned a sleep or a wake function. A time-of-day alarm can wake the device. Writes to a small register port can request shutdown, sleep or a return to normal. The block also drives an active-low reset pin from a set of fault inputs. It keeps sticky status flags and an interrupt line for software to poll or service.

The digital-supply-low comparator is handled in one of two ways, chosen by a configuration bit. It can pull the reset pin low. Otherwise it sets a status flag and raises an interrupt, so software can deal with the brownout itself. A wake event brings the device out of sleep. When the device is already in normal mode, a wake event only sets a flag.

The power-on-reset input is an asynchronous clear for all state. The other inputs are synchronous to `clk`. `pin_lvl`, `alarm` and the fault inputs are expected to be synchronised before they reach this block.

Top module: `pwr_supervisor`

## Requirements
- R1: `rst_n` is low in any cycle where `por`, `wdt_expired` or `xtal_attached` is high, or `clk32k_ready` is low.
- R2: `dvdd_low` pulls `rst_n` low only when the reset-route bit (write address 1, bit 0) is 1. When that bit is 0, `dvdd_low` does not affect `rst_n`.
- R3: Once the last reset source is gone, `rst_n` stays low for HOLD (8) more clock cycles before it goes high.
- R4: When the reset-route bit is 0, `dvdd_low` sets `status[0]`. The flag stays set after `dvdd_low` falls.
- R5: In sleep mode (`mode`=2'b10), a wake event returns the mode to normal (2'b00) on the next edge and does not set `status[1]`.
- R6: In normal mode, a wake event sets `status[1]` and leaves the mode unchanged.
- R7: A wake event is either an `alarm` pulse or a rising edge on the effective level of a pin whose `pin_wake_sel` bit is set. Pins selected for neither function have no effect.
- R8: While any pin selected by `pin_sleep_sel` is active, wake events are ignored and a write cannot leave shutdown.
- R9: Modes are encoded as normal 2'b00, shutdown 2'b01 and sleep 2'b10. Writing address 0 with bit 0 set enters shutdown from any mode. Writing address 0 with bit 1 set (and bit 0 clear), or a rising edge on a sleep-function pin, takes normal mode to sleep. Writing address 0 with 2'b00 returns shutdown to normal. Nothing else leaves shutdown.
- R10: The effective pin level is `pin_lvl ^ pin_pol`, so a 1 in `pin_pol` makes that pin active-low. Edge detection is done on the effective level.
- R11: Writing address 3 clears each status bit where the data has a 1. If a flag is set and cleared in the same cycle, the set wins.
- R12: `irq` is the OR of `status & mask`. The mask is written at address 2, bit 0 for `status[0]` and bit 1 for `status[1]`.
- R13: `por` sets the mode to normal, clears the status flags, sets the reset-route bit to 1 and sets both mask bits to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Power-on reset, active high, asynchronous |
| dvdd_low | input | 1 | Digital-supply-low comparator flag |
| wdt_expired | input | 1 | Watchdog expiry |
| xtal_attached | input | 1 | Crystal oscillator being attached |
| clk32k_ready | input | 1 | 32 kHz clock ready |
| pin_lvl | input | NPIN | Raw pin levels |
| pin_pol | input | NPIN | 1 = pin active-low |
| pin_wake_sel | input | NPIN | Pin has the wake function |
| pin_sleep_sel | input | NPIN | Pin has the sleep function |
| alarm | input | 1 | Time-of-day alarm pulse |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 mode, 1 config, 2 mask, 3 status clear |
| wr_data | input | 2 | Write data |
| rst_n | output | 1 | Active-low reset pin |
| mode | output | 2 | Current power mode |
| status | output | 2 | bit 0 supply low, bit 1 wake seen in normal mode |
| irq | output | 1 | Interrupt |

## Verification
The assertions check these on every cycle:
- Reset sources drive `rst_n` low, and the pin stays low in the cycle after a watchdog expiry.
- The mode encoding stays legal.
- Shutdown is held unless a write arrives.
- Alarm wakes leave sleep without setting a flag, and in normal mode they set the flag without changing the mode.
- The supply flag is sticky, and `irq` stays quiet when no flag is set.

The following can only be shown by the bench scenarios, each compared against the cycle-by-cycle model:
- The exact length of the reset stretch.
- Blocking by the sleep pin.
- Polarity-adjusted pin edges and unconfigured pins.
- Set-over-clear priority.
- What a second power-on reset reloads.

// File: rtl/pwr_supervisor.sv
module pwr_supervisor #(
  parameter int NPIN = 4,
  parameter int HOLD = 8
) (
  input  logic            clk,
  input  logic            por,
  input  logic            dvdd_low,
  input  logic            wdt_expired,
  input  logic            xtal_attached,
  input  logic            clk32k_ready,
  input  logic [NPIN-1:0] pin_lvl,
  input  logic [NPIN-1:0] pin_pol,
  input  logic [NPIN-1:0] pin_wake_sel,
  input  logic [NPIN-1:0] pin_sleep_sel,
  input  logic            alarm,
  input  logic            wr_en,
  input  logic [1:0]      wr_addr,
  input  logic [1:0]      wr_data,
  output logic            rst_n,
  output logic [1:0]      mode,
  output logic [1:0]      status,
  output logic            irq
);
  localparam int CW = $clog2(HOLD + 1);
  localparam logic [1:0] M_NORM = 2'b00, M_SHDN = 2'b01, M_SLP = 2'b10;

  logic [NPIN-1:0] eff, prev;
  logic [CW-1:0]   hold_cnt;
  logic            rst_route;
  logic [1:0]      mask;

  assign eff = pin_lvl ^ pin_pol;

  wire sleep_on   = |(eff & pin_sleep_sel);
  wire sleep_rise = |(eff & ~prev & pin_sleep_sel);
  wire wake       = ((|(eff & ~prev & pin_wake_sel)) | alarm) & ~sleep_on;
  wire fault      = wdt_expired | xtal_attached | ~clk32k_ready | (dvdd_low & rst_route);
  wire wr_mode    = wr_en && wr_addr == 2'd0;
  wire wr_cfg     = wr_en && wr_addr == 2'd1;
  wire wr_mask    = wr_en && wr_addr == 2'd2;
  wire wr_clr     = wr_en && wr_addr == 2'd3;

  wire [1:0] set_bits = {wake && mode == M_NORM, dvdd_low & ~rst_route};
  wire [1:0] clr_bits = wr_clr ? wr_data : 2'b00;

  assign rst_n = ~(por | fault | (hold_cnt != '0));
  assign irq   = |(status & mask);

  always_ff @(posedge clk or posedge por) begin
    if (por) begin
      hold_cnt  <= CW'(HOLD);
      prev      <= '1;
      rst_route <= 1'b1;
      mask      <= 2'b11;
      status    <= 2'b00;
      mode      <= M_NORM;
    end else begin
      prev <= eff;
      if (fault)               hold_cnt <= CW'(HOLD);
      else if (hold_cnt != '0) hold_cnt <= hold_cnt - 1'b1;
      if (wr_cfg)  rst_route <= wr_data[0];
      if (wr_mask) mask      <= wr_data;
      status <= (status & ~clr_bits) | set_bits;
      if (wr_mode && wr_data[0])
        mode <= M_SHDN;
      else if (mode == M_NORM && ((wr_mode && wr_data[1]) || sleep_rise))
        mode <= M_SLP;
      else if (mode == M_SHDN && wr_mode && wr_data == 2'b00 && !sleep_on)
        mode <= M_NORM;
      else if (mode == M_SLP && wake)
        mode <= M_NORM;
    end
  end
endmodule

// File: rtl/pwr_supervisor_chk.sv
module pwr_supervisor_chk #(
  parameter int NPIN = 4
) (
  input logic            clk,
  input logic            por,
  input logic            wdt_expired,
  input logic            xtal_attached,
  input logic            clk32k_ready,
  input logic [NPIN-1:0] pin_sleep_sel,
  input logic            alarm,
  input logic            wr_en,
  input logic [1:0]      wr_addr,
  input logic [1:0]      wr_data,
  input logic            rst_n,
  input logic [1:0]      mode,
  input logic [1:0]      status,
  input logic            irq
);
  p_src_low_r1: assert property (@(posedge clk) disable iff (por)
    (wdt_expired || xtal_attached || !clk32k_ready) |-> !rst_n);

  p_wdt_stretch_r3: assert property (@(posedge clk) disable iff (por)
    $past(wdt_expired) |-> !rst_n);

  p_flag_sticky_r4: assert property (@(posedge clk) disable iff (por)
    (status[0] && !(wr_en && wr_addr == 2'd3 && wr_data[0])) |=> status[0]);

  p_alarm_exit_r5: assert property (@(posedge clk) disable iff (por)
    (mode == 2'b10 && alarm && pin_sleep_sel == '0 && !wr_en)
    |=> (mode == 2'b00 && status[1] == $past(status[1])));

  p_alarm_log_r6: assert property (@(posedge clk) disable iff (por)
    (mode == 2'b00 && alarm && pin_sleep_sel == '0 && !wr_en)
    |=> (mode == 2'b00 && status[1]));

  p_shdn_hold_r9: assert property (@(posedge clk) disable iff (por)
    (mode == 2'b01 && !wr_en) |=> mode == 2'b01);

  p_mode_legal_r9: assert property (@(posedge clk) disable iff (por)
    mode != 2'b11);

  p_irq_quiet_r12: assert property (@(posedge clk) disable iff (por)
    (status == 2'b00) |-> !irq);
endmodule

bind pwr_supervisor pwr_supervisor_chk #(.NPIN(NPIN)) u_chk (
  .clk(clk), .por(por), .wdt_expired(wdt_expired), .xtal_attached(xtal_attached),
  .clk32k_ready(clk32k_ready), .pin_sleep_sel(pin_sleep_sel), .alarm(alarm),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rst_n(rst_n),
  .mode(mode), .status(status), .irq(irq)
);

// File: tb/test_pwr_supervisor.sv
`timescale 1ns/1ps
module test_pwr_supervisor;
  localparam int NPIN = 4;
  localparam int HOLD = 8;

  logic clk = 0;
  logic por = 1, dvdd_low = 0, wdt_expired = 0, xtal_attached = 0, clk32k_ready = 1;
  logic [NPIN-1:0] pin_lvl = 4'b0010, pin_pol = 4'b0010;
  logic [NPIN-1:0] pin_wake_sel = 4'b0010, pin_sleep_sel = 4'b0001;
  logic alarm = 0, wr_en = 0;
  logic [1:0] wr_addr = 0, wr_data = 0;
  logic rst_n, irq;
  logic [1:0] mode, status;

  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  pwr_supervisor #(.NPIN(NPIN), .HOLD(HOLD)) i_pwr_supervisor (
    .clk(clk), .por(por), .dvdd_low(dvdd_low), .wdt_expired(wdt_expired),
    .xtal_attached(xtal_attached), .clk32k_ready(clk32k_ready), .pin_lvl(pin_lvl),
    .pin_pol(pin_pol), .pin_wake_sel(pin_wake_sel), .pin_sleep_sel(pin_sleep_sel),
    .alarm(alarm), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rst_n(rst_n), .mode(mode), .status(status), .irq(irq)
  );

  // reference model
  int m_mode, m_cnt;
  bit [1:0] m_stat, m_mask;
  bit m_route;
  bit [NPIN-1:0] m_prev;

  function automatic bit m_fault();
    return wdt_expired || xtal_attached || !clk32k_ready || (dvdd_low && m_route);
  endfunction

  always @(posedge clk or posedge por) begin
    if (por) begin
      m_mode = 0; m_stat = 0; m_route = 1; m_mask = 3; m_cnt = HOLD; m_prev = '1;
    end else begin
      bit [NPIN-1:0] e;
      bit slp_on, slp_rise, wk;
      bit [1:0] nstat;
      e = pin_lvl ^ pin_pol;
      slp_on = 0; slp_rise = 0; wk = alarm;
      for (int i = 0; i < NPIN; i++) begin
        if (pin_sleep_sel[i] && e[i]) slp_on = 1;
        if (pin_sleep_sel[i] && e[i] && !m_prev[i]) slp_rise = 1;
        if (pin_wake_sel[i] && e[i] && !m_prev[i]) wk = 1;
      end
      if (slp_on) wk = 0;
      if (m_fault()) m_cnt = HOLD; else if (m_cnt > 0) m_cnt--;
      nstat = m_stat;
      if (wr_en && wr_addr == 3) nstat = nstat & ~wr_data;
      if (dvdd_low && !m_route) nstat[0] = 1;
      if (wk && m_mode == 0) nstat[1] = 1;
      if (wr_en && wr_addr == 0 && wr_data[0]) m_mode = 1;
      else if (m_mode == 0 && ((wr_en && wr_addr == 0 && wr_data[1]) || slp_rise)) m_mode = 2;
      else if (m_mode == 1 && wr_en && wr_addr == 0 && wr_data == 0 && !slp_on) m_mode = 0;
      else if (m_mode == 2 && wk) m_mode = 0;
      m_stat = nstat;
      if (wr_en && wr_addr == 1) m_route = wr_data[0];
      if (wr_en && wr_addr == 2) m_mask = wr_data;
      m_prev = e;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    chk("R1 model rst_n", rst_n, !(por || m_fault() || m_cnt > 0));
    chk("R9 model mode", mode, m_mode);
    chk("R11 model status", status, m_stat);
    chk("R12 model irq", irq, |(m_stat & m_mask));
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [1:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    tick(1);
    wr_en = 0;
  endtask

  task automatic alarm_pulse();
    alarm = 1; tick(1); alarm = 0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    tick(3);
    chk("R1 por rst_n", rst_n, 0);
    chk("R13 por mode", mode, 0);
    chk("R13 por status", status, 0);
    por = 0;
    tick(7); chk("R3 stretch low", rst_n, 0);
    tick(1); chk("R3 stretch end", rst_n, 1);

    wdt_expired = 1; #1 chk("R1 wdt", rst_n, 0);
    tick(1); wdt_expired = 0;
    tick(7); chk("R3 wdt stretch", rst_n, 0);
    tick(1); chk("R3 wdt release", rst_n, 1);
    xtal_attached = 1; #1 chk("R1 xtal", rst_n, 0);
    tick(1); xtal_attached = 0; tick(8);
    clk32k_ready = 0; #1 chk("R1 clk not ready", rst_n, 0);
    tick(1); clk32k_ready = 1; tick(8);
    chk("R1 released", rst_n, 1);

    dvdd_low = 1; #1 chk("R2 routed low", rst_n, 0);
    tick(1); chk("R2 no flag when routed", status, 0);
    dvdd_low = 0; tick(8);
    wr(1, 2'b00);
    dvdd_low = 1; #1 chk("R2 unrouted no reset", rst_n, 1);
    tick(1); chk("R4 flag set", status, 1); chk("R12 irq", irq, 1);
    dvdd_low = 0; tick(2); chk("R4 sticky", status, 1);
    wr(2, 2'b10); chk("R12 masked", irq, 0);
    wr(3, 2'b01); chk("R11 clear", status, 0);
    wr(2, 2'b11);
    dvdd_low = 1; wr(3, 2'b01); chk("R11 set wins", status, 1);
    dvdd_low = 0; wr(3, 2'b01); chk("R11 cleared", status, 0);

    alarm_pulse(); chk("R6 flag", status, 2); chk("R6 mode", mode, 0);
    wr(3, 2'b10);
    wr(0, 2'b10); chk("R9 write sleep", mode, 2);
    alarm_pulse(); chk("R5 exit", mode, 0); chk("R5 no flag", status, 0);

    pin_lvl[0] = 1; tick(1); chk("R9 pin sleep", mode, 2);
    alarm_pulse(); chk("R8 blocked", mode, 2);
    pin_lvl[0] = 0; tick(1); chk("R8 still asleep", mode, 2);
    pin_lvl[2] = 1; tick(1); pin_lvl[2] = 0; tick(1);
    chk("R7 unconfigured pin", mode, 2);
    pin_lvl[1] = 0; tick(1); chk("R10 active-low wake", mode, 0);
    pin_lvl[1] = 1; tick(1); chk("R10 release no edge", status, 0);
    pin_lvl[1] = 0; tick(1); chk("R7 pin wake flag", status, 2);
    pin_lvl[1] = 1; wr(3, 2'b10);

    wr(0, 2'b01); chk("R9 shutdown", mode, 1);
    alarm_pulse(); chk("R9 alarm ignored", mode, 1);
    pin_lvl[0] = 1; tick(1); chk("R9 sleep pin in shdn", mode, 1);
    wr(0, 2'b00); chk("R8 exit blocked", mode, 1);
    pin_lvl[0] = 0; tick(1);
    wr(0, 2'b00); chk("R9 exit", mode, 0);

    wr(2, 2'b00); alarm_pulse();
    chk("R12 mask off", irq, 0);
    por = 1; tick(1); por = 0;
    chk("R13 status cleared", status, 0); chk("R13 mode", mode, 0);
    tick(8);
    alarm_pulse(); chk("R13 mask reloaded", irq, 1);
    dvdd_low = 1; #1 chk("R13 route reloaded", rst_n, 0);
    dvdd_low = 0; tick(10);
    finish_run();
  end
endmodule